// File: doc/BRIEF.md
# Batch Tank Sequencer

This controller steps a single mixing tank through one recipe per batch. A start press begins the fill with ingredient A. When the 40 % level switch trips, ingredient B is filled until the 80 % switch trips. The agitator then runs for a fixed minimum time. After that the tank is drained until the empty switch confirms it is dry. The sequence then either runs a timed rinse or goes straight to the ready state, depending on a rinse selector. A further start press begins the next batch.

All operator and level inputs are taken as already synchronized and debounced. Time is counted in units of a one-clock-wide enable pulse, nominally once per millisecond. A stop press is treated as a latching fault: every actuator drops on the next clock and only a synchronous reset clears the fault. Each actuator output is a direct decode of one bit of a one-hot phase register, so no output can be on outside its own phase.

Top module: `batch_sequencer`

## Requirements
- R1: The phase register is one-hot at all times after reset. At most one of the seven outputs is high, and in the idle phase all of them are low.
- R2: A synchronous reset puts the controller in the idle phase (all outputs low) on the next clock. It then stays idle until a start edge arrives.
- R3: A rising edge on `start_btn` in the idle or ready phase moves the controller to fill-A on the next clock (`ready_lamp` drops). Holding start high causes only that one move, and start has no effect in any other phase.
- R4: In fill-A only `valve_a` is high. `lvl_40` high moves the controller to fill-B on the next clock, so `valve_a` closes one clock after the switch trips. `lvl_80` alone is ignored in fill-A.
- R5: In fill-B only `valve_b` is high, and it is never high before fill-A has completed. `lvl_80` high moves the controller to the mix phase on the next clock.
- R6: In the mix phase only `agitator` is high. Its timer is cleared on entry. The controller leaves for drain on the clock after the MIX_MS-th tick counted in the phase, and `drain_valve` stays low until then.
- R7: The phase timers advance only on clocks where `tick_1ms` is high. With the tick held low, the timed phase never ends.
- R8: In the drain phase only `drain_valve` is high. When `lvl_empty` is high, the controller goes to rinse if `wash_sel` is 1, or to ready if it is 0. Without `lvl_empty` it stays in drain whatever `wash_sel` is.
- R9: In the rinse phase only `wash_valve` is high. Its timer is cleared on entry, and the controller leaves for ready on the clock after the WASH_MS-th tick.
- R10: `stop_btn` high at a clock edge in any phase leads, on the next clock, to `fault_lamp` high and every valve, the agitator and `ready_lamp` low. Stop takes priority over every other transition.
- R11: The fault phase is left only by reset, which returns to idle. Start edges and level inputs are ignored while in fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_btn | input | 1 | Start / next-batch button, level |
| stop_btn | input | 1 | Stop button, causes latching fault |
| wash_sel | input | 1 | Rinse selector, 1 = rinse after drain |
| lvl_empty | input | 1 | Tank empty switch |
| lvl_40 | input | 1 | Ingredient-A level switch (40 %) |
| lvl_80 | input | 1 | Combined level switch (80 %) |
| tick_1ms | input | 1 | Timer advance enable, one clock wide |
| valve_a | output | 1 | Ingredient-A inlet valve |
| valve_b | output | 1 | Ingredient-B inlet valve |
| agitator | output | 1 | Agitator motor |
| drain_valve | output | 1 | Tank drain valve |
| wash_valve | output | 1 | Rinse water inlet valve |
| ready_lamp | output | 1 | Batch ready indicator |
| fault_lamp | output | 1 | Fault indicator |

## Verification
Each phase bit drives exactly one output, so a wrong phase register is visible at the ports on the very clock it is loaded. The symptoms are two outputs high together, the wrong output high, or nothing high outside idle. A timer that is off by one or never cleared shows up as an agitator or rinse window one tick longer or shorter than the parameter. It can also show up as a second batch whose window differs from the first. A broken fork or stop path is seen one clock after the triggering input as the wrong valve or a missing fault lamp.

// File: rtl/batch_pkg.sv
package batch_pkg;

  localparam int NUM_PH   = 8;
  localparam int PH_IDLE  = 0;
  localparam int PH_FILLA = 1;
  localparam int PH_FILLB = 2;
  localparam int PH_MIX   = 3;
  localparam int PH_DRAIN = 4;
  localparam int PH_WASH  = 5;
  localparam int PH_READY = 6;
  localparam int PH_FAULT = 7;

  typedef logic [NUM_PH-1:0] ph_vec_t;

  // one-hot vector with only bit idx set
  function automatic ph_vec_t ph_onehot(input int idx);
    ph_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // saturating tick counter step
  function automatic int unsigned tmr_step(input int unsigned cur, input logic adv,
                                           input int unsigned lim);
    if (adv && cur < lim) return cur + 1;
    return cur;
  endfunction

endpackage

// File: rtl/start_edge.sv
module start_edge (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= btn;
  end

  assign pulse = btn & ~prev_q;
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned LIMIT = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  output logic done
);
  import batch_pkg::*;

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = CW'(tmr_step(int'(cnt_q), tick, LIMIT));
  end

  // cleared whenever the owning phase is inactive, so each entry starts at zero
  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else                cnt_q <= cnt_nxt;
  end

  assign done = active && (int'(cnt_q) == LIMIT);
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import batch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stop,
  input  logic    start_pulse,
  input  logic    lvl_40,
  input  logic    lvl_80,
  input  logic    lvl_empty,
  input  logic    wash_sel,
  input  logic    mix_done,
  input  logic    wash_done,
  output ph_vec_t ph_q
);
  ph_vec_t ph_nxt;

  always_comb begin
    ph_nxt = ph_q;
    if (stop) begin
      ph_nxt = ph_onehot(PH_FAULT);
    end else begin
      if (ph_q[PH_IDLE]  && start_pulse)            ph_nxt = ph_onehot(PH_FILLA);
      if (ph_q[PH_FILLA] && lvl_40)                 ph_nxt = ph_onehot(PH_FILLB);
      if (ph_q[PH_FILLB] && lvl_80)                 ph_nxt = ph_onehot(PH_MIX);
      if (ph_q[PH_MIX]   && mix_done)               ph_nxt = ph_onehot(PH_DRAIN);
      if (ph_q[PH_DRAIN] && lvl_empty && wash_sel)  ph_nxt = ph_onehot(PH_WASH);
      if (ph_q[PH_DRAIN] && lvl_empty && !wash_sel) ph_nxt = ph_onehot(PH_READY);
      if (ph_q[PH_WASH]  && wash_done)              ph_nxt = ph_onehot(PH_READY);
      if (ph_q[PH_READY] && start_pulse)            ph_nxt = ph_onehot(PH_FILLA);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= ph_onehot(PH_IDLE);
    else     ph_q <= ph_nxt;
  end
endmodule

// File: rtl/batch_sequencer.sv
module batch_sequencer #(
  parameter int unsigned MIX_MS  = 30000,
  parameter int unsigned WASH_MS = 45000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_btn,
  input  logic stop_btn,
  input  logic wash_sel,
  input  logic lvl_empty,
  input  logic lvl_40,
  input  logic lvl_80,
  input  logic tick_1ms,
  output logic valve_a,
  output logic valve_b,
  output logic agitator,
  output logic drain_valve,
  output logic wash_valve,
  output logic ready_lamp,
  output logic fault_lamp
);
  import batch_pkg::*;

  localparam int NUM_TMR = 2;
  localparam int unsigned TMR_LIM [NUM_TMR] = '{MIX_MS, WASH_MS};
  localparam int          TMR_PH  [NUM_TMR] = '{PH_MIX, PH_WASH};

  ph_vec_t            state_q;
  logic               start_pulse;
  logic [NUM_TMR-1:0] tmr_done;
  logic               mix_done;
  logic               wash_done;

  start_edge u_start (
    .clk   (clk),
    .rst   (rst),
    .btn   (start_btn),
    .pulse (start_pulse)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    phase_timer #(.LIMIT(TMR_LIM[t])) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .active (state_q[TMR_PH[t]]),
      .tick   (tick_1ms),
      .done   (tmr_done[t])
    );
  end

  assign mix_done  = tmr_done[0];
  assign wash_done = tmr_done[1];

  phase_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .stop        (stop_btn),
    .start_pulse (start_pulse),
    .lvl_40      (lvl_40),
    .lvl_80      (lvl_80),
    .lvl_empty   (lvl_empty),
    .wash_sel    (wash_sel),
    .mix_done    (mix_done),
    .wash_done   (wash_done),
    .ph_q        (state_q)
  );

  assign valve_a     = state_q[PH_FILLA];
  assign valve_b     = state_q[PH_FILLB];
  assign agitator    = state_q[PH_MIX];
  assign drain_valve = state_q[PH_DRAIN];
  assign wash_valve  = state_q[PH_WASH];
  assign ready_lamp  = state_q[PH_READY];
  assign fault_lamp  = state_q[PH_FAULT];
endmodule

// File: rtl/batch_seq_chk.sv
module batch_seq_chk
  import batch_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input ph_vec_t state_q,
  input logic    start_pulse,
  input logic    mix_done,
  input logic    stop_btn,
  input logic    lvl_40,
  input logic    lvl_empty,
  input logic    valve_a,
  input logic    valve_b,
  input logic    agitator,
  input logic    drain_valve,
  input logic    wash_valve,
  input logic    ready_lamp,
  input logic    fault_lamp
);
  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  // R2
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> state_q[PH_IDLE]);

  // R3
  start_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && (state_q[PH_IDLE] || state_q[PH_READY]) && !stop_btn) |=> valve_a);

  // R4
  fill_a_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (valve_a && lvl_40) |=> !valve_a);

  // R5
  valve_b_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valve_b) |-> $past(valve_a));

  // R6
  mix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (agitator && !mix_done && !stop_btn) |=> (agitator && !drain_valve));

  // R8
  wash_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wash_valve) |-> $past(drain_valve && lvl_empty));

  // R10
  stop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    stop_btn |=> (fault_lamp && !valve_a && !valve_b && !agitator &&
                  !drain_valve && !wash_valve && !ready_lamp));

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fault_lamp |=> fault_lamp);
endmodule

bind batch_sequencer batch_seq_chk u_batch_seq_chk (
  .clk         (clk),
  .rst         (rst),
  .state_q     (state_q),
  .start_pulse (start_pulse),
  .mix_done    (mix_done),
  .stop_btn    (stop_btn),
  .lvl_40      (lvl_40),
  .lvl_empty   (lvl_empty),
  .valve_a     (valve_a),
  .valve_b     (valve_b),
  .agitator    (agitator),
  .drain_valve (drain_valve),
  .wash_valve  (wash_valve),
  .ready_lamp  (ready_lamp),
  .fault_lamp  (fault_lamp)
);

// File: tb/test_batch_sequencer.sv
module test_batch_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int MIX_T  = 12;
  localparam int WASH_T = 17;
  // phase codes used by the bench only
  localparam int S_IDLE = 0, S_FA = 1, S_FB = 2, S_MIX = 3, S_DRN = 4,
                 S_WASH = 5, S_RDY = 6, S_FLT = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_btn = 1'b0, stop_btn = 1'b0, wash_sel = 1'b0;
  logic lvl_empty = 1'b0, lvl_40 = 1'b0, lvl_80 = 1'b0, tick_1ms = 1'b1;
  logic valve_a, valve_b, agitator, drain_valve, wash_valve, ready_lamp, fault_lamp;
  logic [6:0] outs;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign outs = {fault_lamp, ready_lamp, wash_valve, drain_valve, agitator, valve_b, valve_a};

  batch_sequencer #(.MIX_MS(MIX_T), .WASH_MS(WASH_T)) i_batch_sequencer (
    .clk(clk), .rst(rst), .start_btn(start_btn), .stop_btn(stop_btn),
    .wash_sel(wash_sel), .lvl_empty(lvl_empty), .lvl_40(lvl_40), .lvl_80(lvl_80),
    .tick_1ms(tick_1ms), .valve_a(valve_a), .valve_b(valve_b), .agitator(agitator),
    .drain_valve(drain_valve), .wash_valve(wash_valve), .ready_lamp(ready_lamp),
    .fault_lamp(fault_lamp)
  );

  // each non-idle phase lights exactly the output at position code-1
  function automatic logic [6:0] exp_outs(input int ph);
    if (ph == S_IDLE) return 7'd0;
    return 7'd1 << (ph - 1);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int ph);
    n_chk++;
    if (outs !== exp_outs(ph)) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", tag, outs, exp_outs(ph));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; start_btn = 0; stop_btn = 0; lvl_empty = 0; lvl_40 = 0; lvl_80 = 0;
    tick_1ms = 1'b1;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic press_start();
    start_btn = 1'b1; cyc(1); start_btn = 1'b0;
  endtask

  // walk from reset to the given phase along the recipe
  task automatic run_to(input int ph, input logic wsel);
    do_reset();
    wash_sel = wsel;
    if (ph == S_IDLE) return;
    press_start();
    if (ph == S_FA) return;
    lvl_40 = 1; cyc(1); lvl_40 = 0;
    if (ph == S_FB) return;
    lvl_80 = 1; cyc(1); lvl_80 = 0;
    if (ph == S_MIX) return;
    cyc(MIX_T + 1);
    if (ph == S_DRN) return;
    lvl_empty = 1; cyc(1); lvl_empty = 0;
    if (ph == S_WASH || ph == S_RDY && !wsel) return;
    cyc(WASH_T + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: outputs %b expected run end", outs);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    chk("R2 reset idle", S_IDLE);
    cyc(5);
    chk("R2 idle without start", S_IDLE);

    // R3 held start gives a single move
    start_btn = 1; cyc(1);
    chk("R3 start to fill A", S_FA);
    cyc(4);
    chk("R3 held start single move", S_FA);
    start_btn = 0;
    // R4 lvl_80 ignored in fill A, lvl_40 advances
    lvl_80 = 1; cyc(3);
    chk("R4 lvl_80 ignored in fill A", S_FA);
    lvl_80 = 0; lvl_40 = 1; cyc(1);
    chk("R4 valve A closes, R5 fill B", S_FB);
    start_btn = 1; cyc(1); start_btn = 0;
    chk("R3 start ignored in fill B", S_FB);
    lvl_80 = 1; cyc(1); lvl_80 = 0; lvl_40 = 0;
    chk("R5 lvl_80 to mix", S_MIX);
    // R6 exact agitation window
    cyc(MIX_T);
    chk("R6 still mixing at last tick", S_MIX);
    cyc(1);
    chk("R6 drain after full time", S_DRN);

    // R8 fork on selector, gated by empty switch
    for (int w = 0; w < 2; w++) begin
      run_to(S_DRN, w[0]);
      wash_sel = ~w[0]; cyc(3); wash_sel = w[0];
      chk("R8 drain holds without empty", S_DRN);
      lvl_empty = 1; cyc(1); lvl_empty = 0;
      chk("R8 fork on selector", w[0] ? S_WASH : S_RDY);
      if (w[0]) begin
        cyc(WASH_T);
        chk("R9 rinse still on at last tick", S_WASH);
        cyc(1);
        chk("R9 rinse to ready", S_RDY);
      end
      press_start();
      chk("R3 ready start next batch", S_FA);
      // second batch: timer cleared on entry gives same window
      lvl_40 = 1; cyc(1); lvl_40 = 0; lvl_80 = 1; cyc(1); lvl_80 = 0;
      cyc(MIX_T);
      chk("R6 second batch window", S_MIX);
      cyc(1);
      chk("R6 second batch drain", S_DRN);
    end

    // R7 timer frozen without tick
    run_to(S_MIX, 1'b0);
    tick_1ms = 0; cyc(3 * MIX_T);
    chk("R7 no tick holds mix", S_MIX);
    tick_1ms = 1; cyc(MIX_T);
    chk("R7 counts only ticks", S_MIX);
    cyc(1);
    chk("R7 ends after ticks", S_DRN);
    run_to(S_WASH, 1'b1);
    tick_1ms = 0; cyc(2 * WASH_T);
    chk("R7 no tick holds rinse", S_WASH);
    tick_1ms = 1;

    // R10 stop from every phase, R11 fault sticks
    for (int p = 0; p < 8; p++) begin
      run_to(p == S_FLT ? S_MIX : p, 1'b1);
      if (p == S_FLT) begin stop_btn = 1; cyc(1); stop_btn = 0; end
      stop_btn = 1; cyc(1); stop_btn = 0;
      chk($sformatf("R10 stop from phase %0d", p), S_FLT);
      cyc(3);
      press_start();
      lvl_40 = 1; lvl_80 = 1; lvl_empty = 1; cyc(2);
      lvl_40 = 0; lvl_80 = 0; lvl_empty = 0;
      chk($sformatf("R11 fault held from phase %0d", p), S_FLT);
      rst = 1; cyc(1); rst = 0;
      chk("R11 reset leaves fault", S_IDLE);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule